// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a memory-mapped watchdog that can reset the chip. Software loads a 20-bit tick count into a count register and then sets the run bit in a control register. From then on a prescaler divides the system clock into ticks, and each tick takes one off the count. If software does not reload the count before it reaches zero, the block drives a chip reset pulse for a fixed number of cycles. It also flags the event in a status register and stops itself. Reloading the count while the watchdog runs acts as the keep-alive.

A write to any register is accepted only when the top byte of the write data carries a fixed key. A write without the key changes nothing. The status register also holds boot-hint bits that software sets before a deliberate reset. It is cleared only by the power-on reset input, so the code that runs after a watchdog reset can still read the hints. Reads need no key. They return the register contents with zeros in every bit above the stored field.

Top module: `wdg_keyed_rst`

## Requirements
- R1: A write whose bits 31:24 are not 0x5A leaves the control, status and count registers unchanged and cannot start the watchdog.
- R2: A keyed write to offset 0x24 loads bits 19:0 of the data into the count, and bits 23:20 are dropped. A read of 0x24 returns the count in bits 19:0 and zeros above.
- R3: A keyed write to offset 0x1C stores bits 23:0 of the data as the control value. The watchdog runs while control bit 5 is 1, so the code 2'b10 in bits 5:4 starts it.
- R4: A keyed write of payload 0x102 to the control register stops the watchdog, and the count then holds its value.
- R5: While the watchdog runs, the count decrements once every TICK_DIV cycles. The first decrement lands TICK_DIV cycles after the edge that captures the start write. While the watchdog is stopped, the count never changes on its own.
- R6: When the watchdog runs with a count of zero, wdog_rst_o goes high at the next edge and stays high for exactly RST_CYCLES cycles, and control bits 5:4 are cleared at that same edge. Starting the watchdog with a count of zero therefore fires one cycle later.
- R7: The status register keeps bits 11:0 of a keyed write to offset 0x20. A read returns zeros above bit 11. Bit 6 is set when the watchdog fires, and 0x555 is the halt hint.
- R8: The status register is cleared only by rst_n. Its hint bits are still readable after the watchdog fires.
- R9: A read request returns its data with bus_rvalid one cycle later. An offset the block does not decode reads as zero.
- R10: After rst_n all three registers read zero and wdog_rst_o is low.
- R11: A keyed count write while the watchdog runs reloads the count and restarts the prescaler, so the next decrement is TICK_DIV cycles after the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data: key in 31:24, payload below it |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| wdog_rst_o | output | 1 | Chip reset pulse on expiry |

## Verification
Read data is due one edge after the read strobe is captured, and it shows the register as it stood before that edge. The bench therefore queues each expected value when it issues the read and checks it when bus_rvalid appears. The count's first decrement falls TICK_DIV edges after the start write is captured. The expiry pulse rises one edge after the count reaches zero, at N*TICK_DIV+1 edges after the start, and falls RST_CYCLES edges after that. The bench counts falling edges from the capturing edge and samples wdog_rst_o on the cycle just before it should rise, the cycle it rises, its last high cycle and the cycle after.

// File: rtl/wdg_keyed_pkg.sv
package wdg_keyed_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned KEY_LO = 24;

  localparam logic [7:0] WR_KEY = 8'h5A;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STS  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;

  localparam int unsigned CFG_LO        = 4;
  localparam int unsigned CFG_HI        = 5;
  localparam int unsigned RUN_BIT       = 5;
  localparam int unsigned STS_FIRED_BIT = 6;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STS,
    SEL_CNT
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      OFS_CTRL: sel = SEL_CTRL;
      OFS_STS:  sel = SEL_STS;
      OFS_CNT:  sel = SEL_CNT;
      default:  sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign arst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdg_reg_if.sv
module wdg_reg_if
  import wdg_keyed_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned CTRL_W = 24,
  parameter int unsigned STS_W  = 12
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                expire,
  input  logic [CNT_W-1:0]    count,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [STS_W-1:0]    sts_q,
  output logic                armed,
  output logic                cnt_load,
  output logic [CNT_W-1:0]    cnt_load_val
);

  reg_sel_e            sel;
  logic                key_ok;
  logic                ctrl_we;
  logic                sts_we;
  logic                ctrl_en;
  logic                sts_en;
  logic [CTRL_W-1:0]   ctrl_d;
  logic [STS_W-1:0]    sts_d;
  logic [DATA_W-1:0]   rdata_d;
  logic [DATA_W-1:0]   rdata_q;
  logic                rvalid_q;

  // Write decode: the key gates every register update
  always_comb begin
    sel          = decode_ofs(bus_addr);
    key_ok       = (bus_wdata[DATA_W-1:KEY_LO] == WR_KEY);
    ctrl_we      = bus_wr && key_ok && (sel == SEL_CTRL);
    sts_we       = bus_wr && key_ok && (sel == SEL_STS);
    cnt_load     = bus_wr && key_ok && (sel == SEL_CNT);
    cnt_load_val = bus_wdata[CNT_W-1:0];
  end

  // Control next state: expiry overrides the config field
  always_comb begin
    ctrl_en = ctrl_we || expire;
    ctrl_d  = ctrl_q;
    if (ctrl_we) begin
      ctrl_d = bus_wdata[CTRL_W-1:0];
    end
    if (expire) begin
      ctrl_d[CFG_HI:CFG_LO] = 2'b00;
    end
  end

  // Status next state: expiry forces the fired flag
  always_comb begin
    sts_en = sts_we || expire;
    sts_d  = sts_q;
    if (sts_we) begin
      sts_d = bus_wdata[STS_W-1:0];
    end
    if (expire) begin
      sts_d[STS_FIRED_BIT] = 1'b1;
    end
  end

  // Read mux, key not required
  always_comb begin
    case (sel)
      SEL_CTRL: rdata_d = DATA_W'(ctrl_q);
      SEL_STS:  rdata_d = DATA_W'(sts_q);
      SEL_CNT:  rdata_d = DATA_W'(count);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign armed      = ctrl_q[RUN_BIT];
  assign bus_rdata  = rvalid_q ? rdata_q : '0;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  generate
    if (TICK_DIV == 1) begin : g_pass
      assign tick = run && !restart;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;
      logic          at_last;

      always_comb begin
        at_last = (pre_q == LAST);
        if (!run || restart) begin
          pre_d = '0;
        end else if (at_last) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign tick = run && !restart && at_last;
    end
  endgenerate

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             wdog_rst
);

  localparam int unsigned RW = $clog2(RST_CYCLES + 1);
  localparam logic [RW-1:0] PULSE_LEN = RW'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [RW-1:0]    pulse_q;
  logic [RW-1:0]    pulse_d;
  logic             pulse_en;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = run && at_zero;
  end

  // Count: a reload beats a tick
  always_comb begin
    cnt_en = load || (tick && !at_zero);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  // Reset pulse length counter
  always_comb begin
    pulse_en = expire || (pulse_q != '0);
    if (expire) begin
      pulse_d = PULSE_LEN;
    end else begin
      pulse_d = pulse_q - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pulse_q <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_d;
    end
  end

  assign count    = cnt_q;
  assign wdog_rst = (pulse_q != '0);

endmodule

// File: rtl/wdg_keyed_rst.sv
module wdg_keyed_rst
  import wdg_keyed_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned CTRL_W     = 24,
  parameter int unsigned STS_W      = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        wdog_rst_o
);

  logic              arst_n;
  logic              armed;
  logic              expire;
  logic              tick;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_load_val;
  logic [CNT_W-1:0]  count;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STS_W-1:0]  sts_q;

  wdg_rst_sync #(
    .STAGES (2)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  wdg_reg_if #(
    .CNT_W  (CNT_W),
    .CTRL_W (CTRL_W),
    .STS_W  (STS_W)
  ) u_regs (
    .clk          (clk),
    .arst_n       (arst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .expire       (expire),
    .count        (count),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .ctrl_q       (ctrl_q),
    .sts_q        (sts_q),
    .armed        (armed),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val)
  );

  wdg_tick_gen #(
    .TICK_DIV (TICK_DIV)
  ) u_tick (
    .clk     (clk),
    .arst_n  (arst_n),
    .run     (armed),
    .restart (cnt_load),
    .tick    (tick)
  );

  wdg_countdown #(
    .CNT_W      (CNT_W),
    .RST_CYCLES (RST_CYCLES)
  ) u_cnt (
    .clk      (clk),
    .arst_n   (arst_n),
    .run      (armed),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .count    (count),
    .expire   (expire),
    .wdog_rst (wdog_rst_o)
  );

endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
  import wdg_keyed_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned CTRL_W = 24,
  parameter int unsigned STS_W  = 12
) (
  input logic              clk,
  input logic              arst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              wdog_rst_o,
  input logic              armed,
  input logic [CNT_W-1:0]  count,
  input logic [CTRL_W-1:0] ctrl,
  input logic [STS_W-1:0]  sts
);

  logic     key_ok;
  logic     fire;
  logic     cnt_wr;
  logic     stop_wr;
  reg_sel_e sel;

  always_comb begin
    sel     = decode_ofs(bus_addr);
    key_ok  = (bus_wdata[31:24] == WR_KEY);
    fire    = armed && (count == '0);
    cnt_wr  = bus_wr && key_ok && (sel == SEL_CNT);
    stop_wr = bus_wr && key_ok && (sel == SEL_CTRL) && (bus_wdata[5:4] == 2'b00);
  end

  AST_BADKEY_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_wr && !key_ok && !fire) |=> ($stable(ctrl) && $stable(sts))); // R1

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_wr |=> (count == $past(bus_wdata[CNT_W-1:0]))); // R2

  AST_STOP_DISARM: assert property (@(posedge clk) disable iff (!arst_n)
    stop_wr |=> !armed); // R4

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!arst_n)
    (!armed && !cnt_wr) |=> $stable(count)); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!arst_n)
    (armed && !cnt_wr) |=> ((count == $past(count)) || (count == ($past(count) - CNT_W'(1))))); // R5

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> (wdog_rst_o && !armed)); // R6

  AST_FIRE_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> sts[STS_FIRED_BIT]); // R7

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!arst_n)
    bus_rd |=> bus_rvalid); // R9

  AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    bus_rvalid |-> (bus_rdata[31:24] == 8'h00)); // R9

endmodule

bind wdg_keyed_rst wdg_keyed_chk #(
  .CNT_W  (CNT_W),
  .CTRL_W (CTRL_W),
  .STS_W  (STS_W)
) chk_i (
  .clk        (clk),
  .arst_n     (arst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .wdog_rst_o (wdog_rst_o),
  .armed      (armed),
  .count      (count),
  .ctrl       (ctrl_q),
  .sts        (sts_q)
);

// File: tb/wdg_keyed_rst_tb_top.sv
`timescale 1ns/1ps
module wdg_keyed_rst_tb_top;

  localparam int DIV  = 4;
  localparam int RSTC = 8;

  localparam logic [7:0] A_CTRL = 8'h1C;
  localparam logic [7:0] A_STS  = 8'h20;
  localparam logic [7:0] A_CNT  = 8'h24;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        wdog_rst_o;

  int checks;
  int errors;
  bit done;
  sb_item_t sb_q[$];

  wdg_keyed_rst #(
    .TICK_DIV   (DIV),
    .RST_CYCLES (RSTC)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .wdog_rst_o (wdog_rst_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor: pop the expected read value as each response arrives
  always @(negedge clk) begin
    if (bus_rvalid) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected read data got %h expected none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // Driver tasks: entered at a falling edge, captured at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    bus_rd   = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_pin(input logic e, input string tag);
    checks++;
    if (wdog_rst_o !== e) begin
      errors++;
      $display("FAIL %s: wdog_rst_o got %b expected %b", tag, wdog_rst_o, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: bench timed out got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    @(negedge clk);
    do_reset();

    // R10: reset state
    chk_pin(1'b0, "R10 reset pin");
    rd(A_CTRL, 32'h0, "R10 ctrl");
    rd(A_STS,  32'h0, "R10 sts");
    rd(A_CNT,  32'h0, "R10 cnt");

    // R2: count field width, bits 23:20 dropped
    wr(A_CNT, 32'h5AFFFFFF);
    rd(A_CNT, 32'h000FFFFF, "R2 count field");
    wr(A_CNT, 32'h5A012345);
    rd(A_CNT, 32'h00012345, "R2 count load");

    // R5: decrement rate, first decrement TICK_DIV edges after arming
    wr(A_CNT, 32'h5A000032);
    wr(A_CTRL, 32'h5A000020);
    rd(A_CNT, 32'h32, "R5 before first tick");
    repeat (6) @(negedge clk);
    rd(A_CNT, 32'h31, "R5 one tick");
    rd(A_CNT, 32'h30, "R5 two ticks");
    wr(A_CTRL, 32'h5A000102);

    // R4 and R5: stop freezes the count
    wr(A_CNT, 32'h5A000064);
    wr(A_CTRL, 32'h5A000020);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h5A000102);
    repeat (20) @(negedge clk);
    rd(A_CNT, 32'h62, "R4 count frozen after stop");
    rd(A_CTRL, 32'h102, "R4 ctrl stop value");

    // R11: reload while running restarts the prescaler
    wr(A_CNT, 32'h5A000064);
    wr(A_CTRL, 32'h5A000020);
    repeat (5) @(negedge clk);
    wr(A_CNT, 32'h5A00001E);
    rd(A_CNT, 32'h1E, "R11 reload value");
    wr(A_CTRL, 32'h5A000102);
    rd(A_CNT, 32'h1E, "R11 no early tick");

    // R7: hints before expiry
    wr(A_STS, 32'h5A000015);
    rd(A_STS, 32'h15, "R7 hint write");

    // R3 and R6: expiry timing with count 3
    wr(A_CNT, 32'h5A000003);
    wr(A_CTRL, 32'h5A000321);
    repeat (3*DIV) @(negedge clk);
    chk_pin(1'b0, "R6 low before expiry");
    @(negedge clk);
    chk_pin(1'b1, "R6 rises after zero");
    repeat (RSTC-1) @(negedge clk);
    chk_pin(1'b1, "R6 last pulse cycle");
    @(negedge clk);
    chk_pin(1'b0, "R6 pulse ended");
    rd(A_CTRL, 32'h301, "R3 ctrl kept, R6 cfg cleared");
    rd(A_STS,  32'h55,  "R7 fired flag, R8 hints kept");
    rd(A_CNT,  32'h0,   "R6 count at zero");

    // R6: arming with zero count fires on the next edge
    wr(A_CTRL, 32'h5A000020);
    chk_pin(1'b0, "R6 zero count arm edge");
    @(negedge clk);
    chk_pin(1'b1, "R6 zero count fires");
    repeat (RSTC+2) @(negedge clk);

    // R1: writes without the key change nothing
    wr(A_CNT,  32'h00000123);
    wr(A_CTRL, 32'hA5000020);
    wr(A_STS,  32'h5B000FFF);
    repeat (20) @(negedge clk);
    chk_pin(1'b0, "R1 no start without key");
    rd(A_CNT,  32'h0,  "R1 count unchanged");
    rd(A_CTRL, 32'h0,  "R1 ctrl unchanged");
    rd(A_STS,  32'h55, "R1 sts unchanged");

    // R7: halt hint and status width
    wr(A_STS, 32'h5A000555);
    rd(A_STS, 32'h555, "R7 halt hint");
    wr(A_STS, 32'h5AFFFFFF);
    rd(A_STS, 32'hFFF, "R7 status width");

    // R9: undecoded offsets
    rd(8'h28, 32'h0, "R9 unknown offset");
    rd(8'h00, 32'h0, "R9 offset zero");

    // R8: only the power-on reset clears status
    do_reset();
    rd(A_STS,  32'h0, "R8 status cleared by rst_n");
    rd(A_CTRL, 32'h0, "R10 ctrl after rst_n");
    chk_pin(1'b0, "R10 pin after rst_n");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R9: pending reads got %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule